// File: doc/BRIEF.md
# EEPROM Status Register and Write-Protection Unit

This block keeps the status register of a 4096-byte serial EEPROM. It also decides, in the cycle a request arrives, whether a memory write or a status write may go ahead. The serial front end and the opcode decoder sit upstream. They deliver single-cycle command strobes: set the enable latch, clear the enable latch, load the status register (with a data byte), read the status register, and write memory at a 12-bit address. The level of the external write-protect pin is also an input. Non-volatile storage is outside the block; the stored protection bits are modelled as reset values set by parameters.

The block answers each memory or status write with a grant or a deny pulse in the same cycle. Each granted write starts an internal write-cycle timer of `TWC` clock cycles. While the timer runs the block reports busy and ignores every write-type command. When the timer expires, busy drops and the enable latch clears. The status byte is driven out whenever the read strobe is high.

Top module: `eep_status_guard`

## Requirements
- R1: While `stat_rd_i` is 1, `status_o` carries {lock-enable, 0, 0, 0, range-select[1], range-select[0], enable latch, busy}, bit 7 down to bit 0. While `stat_rd_i` is 0, `status_o` is 0.
- R2: After reset the enable latch and busy read 0. The lock-enable bit takes `LOCK_EN_RST` and the range select takes `RANGE_RST`.
- R3: With busy at 0, `wel_set_i` sets the enable latch and `wel_clr_i` clears it.
- R4: While the enable latch is 0, every memory write and every status write is denied.
- R5: The range select chooses which addresses are read-only: 00 none, 01 0xC00–0xFFF, 10 0x800–0xFFF, 11 all addresses. A memory write into the selected range is denied whatever the other bits are.
- R6: The hardware lock is active when `wp_pin_i` is 0 and the lock-enable bit is 1. While it is active, status writes are denied, but memory writes outside the read-only range are still granted when the enable latch is 1.
- R7: A granted status write loads lock-enable from data bit 7 and the range select from data bits 3:2. The other data bits have no effect.
- R8: A granted write sets busy for exactly `TWC` cycles, starting on the next clock edge. When busy falls, the enable latch is 0.
- R9: While busy is 1, memory writes and status writes are denied, and the enable-latch commands have no effect. Status reads return the live busy bit.
- R10: A denied write leaves the enable latch unchanged and does not start a write cycle.
- R11: Each memory write request gets exactly one of `mem_grant_o` or `mem_deny_o` in its own cycle. Each status write request gets exactly one of `stat_grant_o` or `stat_deny_o` in its own cycle.
- R12: At most one command is acted on per cycle, chosen in the order memory write, status write, latch set, latch clear. A lower-priority strobe in the same cycle produces no grant, no deny and no state change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wel_set_i | input | 1 | Command strobe: set the enable latch |
| wel_clr_i | input | 1 | Command strobe: clear the enable latch |
| stat_wr_i | input | 1 | Command strobe: status write |
| stat_data_i | input | 8 | Data byte for the status write |
| stat_rd_i | input | 1 | Status read strobe |
| mem_wr_i | input | 1 | Memory write request |
| mem_addr_i | input | 12 | Memory write address |
| wp_pin_i | input | 1 | Write-protect pin level (0 = low) |
| status_o | output | 8 | Status byte while reading, otherwise 0 |
| mem_grant_o | output | 1 | Memory write allowed |
| mem_deny_o | output | 1 | Memory write refused |
| stat_grant_o | output | 1 | Status write allowed |
| stat_deny_o | output | 1 | Status write refused |
| busy_o | output | 1 | Write cycle in progress |

## Verification
The hardest cases to reach need a status write that first sets the lock-enable bit, then a pin level that holds the lock, and then a second write attempt made while the enable latch is still 1. The same applies to a write that falls exactly on the cycle busy drops. Directed sequences build these states through the command ports. Long random runs then mix latch commands, status writes with random data, pin toggling and addresses near the 0x800 and 0xC00 boundaries. As a result, every combination of range select, lock and latch recurs many times, including the cycles at the edge of a write cycle.

// File: rtl/eep_prot_pkg.sv
package eep_prot_pkg;

  typedef enum logic [1:0] {
    RANGE_NONE = 2'b00,
    RANGE_QTR  = 2'b01,
    RANGE_HALF = 2'b10,
    RANGE_ALL  = 2'b11
  } range_sel_e;

  typedef enum logic [2:0] {
    CMD_IDLE,
    CMD_MEM,
    CMD_STAT,
    CMD_SET,
    CMD_CLR
  } cmd_e;

  function automatic logic [7:0] pack_status(logic lock_en, range_sel_e rsel,
                                             logic wel, logic busy);
    return {lock_en, 3'b000, rsel, wel, busy};
  endfunction

endpackage

// File: rtl/eep_range_guard.sv
module eep_range_guard
  import eep_prot_pkg::*;
#(
  parameter int unsigned AW = 12
) (
  input  range_sel_e       rsel_i,
  input  logic [AW-1:0]    addr_i,
  output logic             locked_o
);
  localparam int unsigned TOP = AW - 1;

  // read-only region: upper quarter, upper half or everything
  always_comb begin
    unique case (rsel_i)
      RANGE_NONE: locked_o = 1'b0;
      RANGE_QTR:  locked_o = addr_i[TOP] & addr_i[TOP-1];
      RANGE_HALF: locked_o = addr_i[TOP];
      default:    locked_o = 1'b1;
    endcase
  end
endmodule

// File: rtl/eep_wc_timer.sv
module eep_wc_timer #(
  parameter int unsigned TWC = 8
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  output logic busy_o,
  output logic done_o
);
  localparam int unsigned CW = (TWC > 1) ? $clog2(TWC) : 1;
  localparam logic [CW-1:0] CNT_LOAD = CW'(TWC - 1);

  logic [CW-1:0] cnt_q;
  logic          busy_q;

  assign done_o = busy_q && (cnt_q == '0);
  assign busy_o = busy_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
    end else if (busy_q) begin
      if (cnt_q == '0) busy_q <= 1'b0;
      else             cnt_q  <= cnt_q - 1'b1;
    end else if (start_i) begin
      busy_q <= 1'b1;
      cnt_q  <= CNT_LOAD;
    end
  end

  a_r8_start_sets_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> busy_o);
  a_r9_no_start_when_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> !start_i);
endmodule

// File: rtl/eep_ctrl_regs.sv
module eep_ctrl_regs
  import eep_prot_pkg::*;
#(
  parameter logic       LOCK_EN_RST = 1'b0,
  parameter range_sel_e RANGE_RST   = RANGE_NONE
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       wel_set_i,
  input  logic       wel_clr_i,
  input  logic       sr_load_i,
  input  logic       sr_lock_en_i,
  input  range_sel_e sr_rsel_i,
  output logic       wel_o,
  output logic       lock_en_o,
  output range_sel_e rsel_o
);
  logic       wel_q;
  logic       lock_en_q;
  range_sel_e rsel_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        wel_q <= 1'b0;
    else if (wel_clr_i) wel_q <= 1'b0;
    else if (wel_set_i) wel_q <= 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lock_en_q <= LOCK_EN_RST;
      rsel_q    <= RANGE_RST;
    end else if (sr_load_i) begin
      lock_en_q <= sr_lock_en_i;
      rsel_q    <= sr_rsel_i;
    end
  end

  assign wel_o     = wel_q;
  assign lock_en_o = lock_en_q;
  assign rsel_o    = rsel_q;

  a_r7_sr_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sr_load_i |=> $stable({lock_en_q, rsel_q}));
  a_r3_wel_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wel_set_i && !wel_clr_i) |=> wel_q);
endmodule

// File: rtl/eep_status_guard.sv
module eep_status_guard
  import eep_prot_pkg::*;
#(
  parameter int unsigned AW          = 12,
  parameter int unsigned TWC         = 8,
  parameter logic        LOCK_EN_RST = 1'b0,
  parameter logic [1:0]  RANGE_RST   = 2'b00
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wel_set_i,
  input  logic          wel_clr_i,
  input  logic          stat_wr_i,
  input  logic [7:0]    stat_data_i,
  input  logic          stat_rd_i,
  input  logic          mem_wr_i,
  input  logic [AW-1:0] mem_addr_i,
  input  logic          wp_pin_i,
  output logic [7:0]    status_o,
  output logic          mem_grant_o,
  output logic          mem_deny_o,
  output logic          stat_grant_o,
  output logic          stat_deny_o,
  output logic          busy_o
);
  cmd_e       cmd;
  logic       wel, lock_en, busy, done, addr_locked, hw_lock, start;
  range_sel_e rsel;
  logic       unused_data;

  assign unused_data = ^{stat_data_i[6:4], stat_data_i[1:0]};

  // one command per cycle, fixed priority
  always_comb begin
    if      (mem_wr_i)  cmd = CMD_MEM;
    else if (stat_wr_i) cmd = CMD_STAT;
    else if (wel_set_i) cmd = CMD_SET;
    else if (wel_clr_i) cmd = CMD_CLR;
    else                cmd = CMD_IDLE;
  end

  eep_range_guard #(.AW(AW)) u_range (
    .rsel_i  (rsel),
    .addr_i  (mem_addr_i),
    .locked_o(addr_locked)
  );

  assign hw_lock      = !wp_pin_i && lock_en;
  assign mem_grant_o  = (cmd == CMD_MEM)  && !busy && wel && !addr_locked;
  assign mem_deny_o   = (cmd == CMD_MEM)  && !mem_grant_o;
  assign stat_grant_o = (cmd == CMD_STAT) && !busy && wel && !hw_lock;
  assign stat_deny_o  = (cmd == CMD_STAT) && !stat_grant_o;
  assign start        = mem_grant_o || stat_grant_o;

  eep_wc_timer #(.TWC(TWC)) u_timer (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .start_i(start),
    .busy_o (busy),
    .done_o (done)
  );

  eep_ctrl_regs #(
    .LOCK_EN_RST(LOCK_EN_RST),
    .RANGE_RST  (range_sel_e'(RANGE_RST))
  ) u_regs (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .wel_set_i   ((cmd == CMD_SET) && !busy),
    .wel_clr_i   (done || ((cmd == CMD_CLR) && !busy)),
    .sr_load_i   (stat_grant_o),
    .sr_lock_en_i(stat_data_i[7]),
    .sr_rsel_i   (range_sel_e'(stat_data_i[3:2])),
    .wel_o       (wel),
    .lock_en_o   (lock_en),
    .rsel_o      (rsel)
  );

  assign status_o = stat_rd_i ? pack_status(lock_en, rsel, wel, busy) : 8'h00;
  assign busy_o   = busy;

  a_r4_no_wel_no_grant: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !status_o[1] && stat_rd_i |-> !(mem_grant_o || stat_grant_o));
  a_r5_all_locked: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsel == RANGE_ALL) |-> !mem_grant_o);
  a_r6_lock_blocks_sr: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!wp_pin_i && lock_en) |-> !stat_grant_o);
  a_r8_end_clears_wel: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> !wel);
  a_r9_busy_no_grant: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> !(mem_grant_o || stat_grant_o));
  a_r10_deny_no_cycle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((mem_deny_o || stat_deny_o) && !busy_o) |=> (!busy_o && $stable(wel)));
  a_r11_one_answer: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({mem_grant_o, mem_deny_o, stat_grant_o, stat_deny_o}));
  a_r12_mem_first: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_wr_i |-> !(stat_grant_o || stat_deny_o));
endmodule

// File: tb/eep_status_guard_tb.sv
`timescale 1ns/1ps
module eep_status_guard_tb;
  localparam int unsigned TWC       = 5;
  localparam logic        LOCK_RST  = 1'b1;
  localparam logic [1:0]  RANGE_RST = 2'b01;

  logic clk = 1'b0, rst_n = 1'b0;
  logic wel_set, wel_clr, stat_wr, stat_rd, mem_wr, wp_pin;
  logic [7:0] stat_data, status;
  logic [11:0] addr;
  logic mem_grant, mem_deny, stat_grant, stat_deny, busy;

  always #2.5 clk = ~clk;

  eep_status_guard #(.AW(12), .TWC(TWC), .LOCK_EN_RST(LOCK_RST), .RANGE_RST(RANGE_RST)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .wel_set_i(wel_set), .wel_clr_i(wel_clr),
    .stat_wr_i(stat_wr), .stat_data_i(stat_data), .stat_rd_i(stat_rd),
    .mem_wr_i(mem_wr), .mem_addr_i(addr), .wp_pin_i(wp_pin), .status_o(status),
    .mem_grant_o(mem_grant), .mem_deny_o(mem_deny), .stat_grant_o(stat_grant),
    .stat_deny_o(stat_deny), .busy_o(busy));

  int n_chk = 0, n_fail = 0;
  bit finished = 0;
  logic m_wel, m_busy, m_lock;
  logic [1:0] m_rsel;
  int m_cnt;

  function automatic logic in_range(logic [1:0] rs, logic [11:0] a);
    case (rs)
      2'b00:   return 1'b0;
      2'b01:   return a >= 12'hC00;
      2'b10:   return a >= 12'h800;
      default: return 1'b1;
    endcase
  endfunction

  task automatic check(input string tag, input logic [12:0] act, input logic [12:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  task automatic step(input logic mw, input logic [11:0] a, input logic sw,
                      input logic [7:0] d, input logic we, input logic wd,
                      input logic rd, input logic wp, input string tag_in);
    logic mg, md, sg, sd, prot, lock;
    logic [7:0] st;
    string tag;
    @(negedge clk);
    mem_wr = mw; addr = a; stat_wr = sw; stat_data = d;
    wel_set = we; wel_clr = wd; stat_rd = rd; wp_pin = wp;
    #1;
    prot = in_range(m_rsel, a);
    lock = !wp && m_lock;
    mg = mw && !m_busy && m_wel && !prot;
    md = mw && !mg;
    sg = !mw && sw && !m_busy && m_wel && !lock;
    sd = !mw && sw && !sg;
    st = rd ? {m_lock, 3'b000, m_rsel, m_wel, m_busy} : 8'h00;
    if (tag_in != "")                 tag = tag_in;
    else if (m_busy)                  tag = "R9";
    else if ((mw + sw + we + wd) > 1) tag = "R12";
    else if ((mw || sw) && !m_wel)    tag = "R4";
    else if (mw && prot)              tag = "R5";
    else if (sw && lock)              tag = "R6";
    else if (sw)                      tag = "R7";
    else if (mw)                      tag = "R8";
    else if (we || wd)                tag = "R3";
    else                              tag = "R1";
    check(tag, {mem_grant, mem_deny, stat_grant, stat_deny, busy, status},
               {mg, md, sg, sd, m_busy, st});
    // model next state
    if (m_busy) begin
      if (m_cnt == 0) begin m_busy = 0; m_wel = 0; end
      else m_cnt--;
    end else if (mg || sg) begin
      m_busy = 1; m_cnt = TWC - 1;
      if (sg) begin m_lock = d[7]; m_rsel = d[3:2]; end
    end else if (!mw && !sw && we) m_wel = 1;
    else if (!mw && !sw && wd) m_wel = 0;
  endtask

  task automatic idle(input int n, input string tag);
    for (int i = 0; i < n; i++) step(0, 12'h0, 0, 8'h0, 0, 0, 1, 1, tag);
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    #200000;
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: got hang expected completion");
      finish_run();
    end
  end

  initial begin
    void'($urandom(32'd4242));
    {wel_set, wel_clr, stat_wr, stat_rd, mem_wr} = '0;
    stat_data = '0; addr = '0; wp_pin = 1'b1;
    m_wel = 0; m_busy = 0; m_lock = LOCK_RST; m_rsel = RANGE_RST; m_cnt = 0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    // R2: reset values of latch, busy and stored bits
    step(0, 12'h0, 0, 8'h0, 0, 0, 1, 1, "R2");
    // R4: writes refused with latch clear
    step(1, 12'h100, 0, 8'h0, 0, 0, 1, 1, "R4");
    step(0, 12'h0, 1, 8'h00, 0, 0, 1, 1, "R4");
    step(0, 12'h0, 0, 8'h0, 1, 0, 1, 1, "R3");
    // R5: quarter range, 0xC00 refused, 0xBFF accepted
    step(1, 12'hC00, 0, 8'h0, 0, 0, 1, 1, "R5");
    step(0, 12'h0, 0, 8'h0, 0, 0, 1, 1, "R10");
    step(1, 12'hBFF, 0, 8'h0, 0, 0, 1, 1, "R8");
    idle(TWC + 1, "R8");
    // R6: lock held by pin low and lock bit 1
    step(0, 12'h0, 0, 8'h0, 1, 0, 1, 0, "R3");
    step(0, 12'h0, 1, 8'h0C, 0, 0, 1, 0, "R6");
    step(1, 12'h0FF, 0, 8'h0, 0, 0, 1, 0, "R6");
    step(0, 12'h0, 1, 8'h0C, 1, 0, 1, 0, "R9");
    idle(TWC, "R9");
    // R7: pin high, load all-range with junk bits in 6:4 and 1:0
    step(0, 12'h0, 0, 8'h0, 1, 0, 1, 1, "R3");
    step(0, 12'h0, 1, 8'h7F, 0, 0, 1, 1, "R7");
    idle(TWC + 1, "R7");
    step(0, 12'h0, 0, 8'h0, 1, 0, 1, 1, "R3");
    step(1, 12'h000, 0, 8'h0, 0, 0, 1, 1, "R5");
    // R12: memory request outranks the others
    step(1, 12'h000, 1, 8'h00, 1, 1, 1, 1, "R12");
    step(0, 12'h0, 0, 8'h0, 1, 1, 1, 1, "R12");
    step(0, 12'h0, 0, 8'h0, 0, 1, 1, 1, "R3");
    // random mix
    for (int i = 0; i < 4000; i++) begin
      logic [11:0] a;
      int sel = $urandom_range(0, 3);
      a = (sel == 0) ? 12'hC00 - 12'($urandom_range(0, 2)) + 12'($urandom_range(0, 1)) * 12'd2 :
          (sel == 1) ? 12'h800 - 12'($urandom_range(0, 2)) + 12'($urandom_range(0, 1)) * 12'd2 :
                       12'($urandom);
      step($urandom_range(0, 5) == 0, a, $urandom_range(0, 5) == 0, 8'($urandom),
           $urandom_range(0, 2) == 0, $urandom_range(0, 6) == 0,
           $urandom_range(0, 3) != 0, $urandom_range(0, 1) == 1, "");
    end
    finished = 1;
    finish_run();
  end
endmodule